// File: doc/BRIEF.md
# Pixel-Clock Panel Timing Generator

The block drives the sync and enable strobes of a parallel RGB panel, one pixel per clock. A line counter tracks the horizontal position and a second counter tracks the pixel index within the whole frame. All vertical events (vertical sync, display start and end, active window start and end) are matched against that frame-wide index and not against a line number. Software can therefore place a vertical edge at any pixel of a line, which is how a fixed horizontal-to-vertical skew is applied.

Inside the display rectangle an optional smaller active window can be enabled separately on each axis. Display pixels outside the window are filled with a programmable border color while data enable stays high. Inside the window the block requests pixels from an upstream source through a ready/valid pair. If the source has nothing to give, the block shows a programmable underflow color and latches a sticky underflow flag. The block either recovers at the next frame start or holds the underflow color until it is restarted. Clearing the run input lets the current frame end cleanly, after which every output rests at its inactive level.

Top module: `lcd_timing_gen`

## Requirements
- R1: The line counter runs from 0 to `cfg_hctl[31:16]`-1. The logical horizontal sync is high while the line position is below `cfg_hctl[15:0]`.
- R2: The frame counter runs from 0 to `cfg_frame_len`-1, and the line counter also returns to 0 when the frame wraps. The logical vertical sync is high while the frame index p satisfies `cfg_skew` <= p < `cfg_skew` + `cfg_vs_len`.
- R3: The logical data enable is high exactly when the line position lies in [`cfg_disp_h[15:0]`, `cfg_disp_h[31:16]`] and the frame index lies in [`cfg_disp_vs`, `cfg_disp_ve`]. Both ranges are inclusive.
- R4: With `cfg_win_h_en` set, the active window is limited to line positions in [`cfg_win_h[15:0]`, `cfg_win_h[31:16]`]. With `cfg_win_v_en` set, it is limited to frame indices in [`cfg_win_vs`, `cfg_win_ve`]. With a flag clear, that axis spans the whole display area. Display pixels outside the window show `cfg_border`, and data enable stays high.
- R5: Inside the active window `pix_ready` is high. Accepted source pixels appear on `rgb` in the order they were accepted. Outside the display area `rgb` is 0.
- R6: When `cfg_pol` bit 0 is set, the hsync output is inverted. Bit 1 inverts vsync and bit 2 inverts data enable. When the generator is stopped, each of these outputs equals its polarity bit.
- R7: An active-window pixel with `pix_valid` low shows the color in `cfg_uflow[CW-1:0]` and sets the sticky `underflow` output, which only reset clears. The source is then not read, and the underflow color is shown on every active pixel until the hold ends. If `cfg_uflow[CW]` is 1, the hold ends at the next frame start. If it is 0, the hold ends when the generator is restarted.
- R8: Raising `run_en` while stopped puts pixel 0 of a frame on the outputs at the second rising clock edge. Lowering `run_en` lets the frame in progress finish. After that, the outputs are idle with `rgb` = 0, and no further `frame_start` is produced.
- R9: `frame_start` is a one-cycle pulse that accompanies pixel 0 of every frame. All outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | 1 starts the generator, 0 stops it at the end of the frame |
| cfg_hctl | input | 2*HW | Line period [31:16], hsync width [15:0] |
| cfg_frame_len | input | FW | Pixels per frame |
| cfg_vs_len | input | FW | Vertical sync width in pixels |
| cfg_skew | input | FW | Pixel offset of the vertical sync leading edge |
| cfg_disp_h | input | 2*HW | Display end x [31:16], start x [15:0] |
| cfg_disp_vs | input | FW | Display start frame index |
| cfg_disp_ve | input | FW | Display end frame index |
| cfg_win_h_en | input | 1 | Restrict the active window horizontally |
| cfg_win_h | input | 2*HW | Window end x [31:16], start x [15:0] |
| cfg_win_v_en | input | 1 | Restrict the active window vertically |
| cfg_win_vs | input | FW | Window start frame index |
| cfg_win_ve | input | FW | Window end frame index |
| cfg_pol | input | 3 | Inversion: bit0 hsync, bit1 vsync, bit2 data enable |
| cfg_border | input | CW | Border color |
| cfg_uflow | input | CW+1 | Underflow color [CW-1:0], recovery enable [CW] |
| pix_valid | input | 1 | Source has a pixel |
| pix_data | input | CW | Source pixel |
| pix_ready | output | 1 | Block takes the source pixel this cycle |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| rgb | output | CW | Pixel color |
| frame_start | output | 1 | Pulse with pixel 0 of each frame |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The hardest case to reach from the ports is the end of an underflow hold. The hold must end at the next frame boundary when recovery is enabled, and only on a restart when it is not. The stimulus source counts the cycles in which the block requests a pixel and withholds valid in exactly one chosen request. Two-frame runs are then made with recovery on and with recovery off, and a following fresh run shows that a restart clears the hold. A run with a nonzero skew and an enabled window places the vertical edges in the middle of a line, so border pixels and window edges fall mid-row.

// File: rtl/lcdtg_pkg.sv
// Shared types for the panel timing generator.
package lcdtg_pkg;

    // Per-pixel region flags produced by the window logic.
    typedef struct packed {
        logic hs;    // inside horizontal sync pulse
        logic vs;    // inside vertical sync pulse
        logic disp;  // inside display rectangle
        logic act;   // inside active window (subset of disp)
    } zone_t;

    // Selected color source for the output stage.
    typedef enum logic [1:0] {
        SRC_BLANK  = 2'd0,
        SRC_BORDER = 2'd1,
        SRC_PIXEL  = 2'd2,
        SRC_UFLOW  = 2'd3
    } src_e;

endpackage

// File: rtl/lcdtg_scan_ctr.sv
// Line and frame pixel counters with run/stop control.
// Assumes the frame length is a whole number of lines and that the
// configuration does not change while the generator runs.
// A stop request takes effect only when the frame counter wraps.
module lcdtg_scan_ctr #(
    parameter int HW = 16,
    parameter int FW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [HW-1:0] line_len,
    input  logic [FW-1:0] frame_len,
    output logic          run_q,
    output logic [HW-1:0] hcnt_q,
    output logic [FW-1:0] fcnt_q,
    output logic          start_o,
    output logic          fzero_o
);
    logic h_wrap;
    logic f_wrap;

    // Wrap detection tolerant of a counter already past the limit.
    always_comb begin
        h_wrap  = ((HW+1)'(hcnt_q) + (HW+1)'(1)) >= (HW+1)'(line_len);
        f_wrap  = ((FW+1)'(fcnt_q) + (FW+1)'(1)) >= (FW+1)'(frame_len);
        start_o = !run_q && run_en;
        fzero_o = run_q && (fcnt_q == '0);
    end

    // Counter advance, start from idle and stop at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            hcnt_q <= '0;
            fcnt_q <= '0;
        end else if (!run_q) begin
            hcnt_q <= '0;
            fcnt_q <= '0;
            if (run_en) begin
                run_q <= 1'b1;
            end
        end else if (f_wrap) begin
            hcnt_q <= '0;
            fcnt_q <= '0;
            if (!run_en) begin
                run_q <= 1'b0;
            end
        end else begin
            fcnt_q <= fcnt_q + 1'b1;
            hcnt_q <= h_wrap ? '0 : hcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/lcdtg_window.sv
// Region decode: compares the counters against the sync, display and
// active-window limits. Horizontal limits are line positions, vertical
// limits are frame pixel indices. All ranges are inclusive except the
// sync pulses, which are [start, start+width).
module lcdtg_window #(
    parameter int HW = 16,
    parameter int FW = 32
) (
    input  logic [HW-1:0]         hcnt,
    input  logic [FW-1:0]         fcnt,
    input  logic [HW-1:0]         hs_len,
    input  logic [FW-1:0]         vs_len,
    input  logic [FW-1:0]         skew,
    input  logic [HW-1:0]         disp_h_start,
    input  logic [HW-1:0]         disp_h_end,
    input  logic [FW-1:0]         disp_v_start,
    input  logic [FW-1:0]         disp_v_end,
    input  logic                  win_h_en,
    input  logic [HW-1:0]         win_h_start,
    input  logic [HW-1:0]         win_h_end,
    input  logic                  win_v_en,
    input  logic [FW-1:0]         win_v_start,
    input  logic [FW-1:0]         win_v_end,
    output lcdtg_pkg::zone_t      zone
);
    logic [FW:0] vs_stop;
    logic        in_disp_h;
    logic        in_disp_v;
    logic        in_win_h;
    logic        in_win_v;

    // Range comparisons and region flags for the current pixel.
    always_comb begin
        vs_stop   = (FW+1)'(skew) + (FW+1)'(vs_len);
        in_disp_h = (hcnt >= disp_h_start) && (hcnt <= disp_h_end);
        in_disp_v = (fcnt >= disp_v_start) && (fcnt <= disp_v_end);
        in_win_h  = !win_h_en || ((hcnt >= win_h_start) && (hcnt <= win_h_end));
        in_win_v  = !win_v_en || ((fcnt >= win_v_start) && (fcnt <= win_v_end));
        zone.hs   = hcnt < hs_len;
        zone.vs   = (fcnt >= skew) && ((FW+1)'(fcnt) < vs_stop);
        zone.disp = in_disp_h && in_disp_v;
        zone.act  = in_disp_h && in_disp_v && in_win_h && in_win_v;
    end

endmodule

// File: rtl/lcdtg_pixel_out.sv
// Output stage: color selection, underflow hold, polarity and the
// output registers. Assumes the zone flags describe the pixel the
// counters hold this cycle; every output shows that pixel one edge later.
module lcdtg_pixel_out #(
    parameter int CW = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fzero,
    input  logic             start,
    input  lcdtg_pkg::zone_t zone,
    input  logic [2:0]       pol,
    input  logic [CW-1:0]    border,
    input  logic [CW-1:0]    uflow_color,
    input  logic             recover,
    input  logic             pix_valid,
    input  logic [CW-1:0]    pix_data,
    output logic             pix_ready,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [CW-1:0]    rgb_o,
    output logic             fs_o,
    output logic             uf_o
);
    import lcdtg_pkg::*;

    logic hold_q;
    logic hold_eff;
    logic starve;
    logic hold_d;
    src_e src;

    // Hold release at frame start, starvation detection and source select.
    always_comb begin
        hold_eff  = hold_q && !(recover && fzero);
        pix_ready = run && zone.act && !hold_eff;
        starve    = pix_ready && !pix_valid;
        hold_d    = hold_eff || starve;
        if (!run || !zone.disp) begin
            src = SRC_BLANK;
        end else if (!zone.act) begin
            src = SRC_BORDER;
        end else if (hold_eff || !pix_valid) begin
            src = SRC_UFLOW;
        end else begin
            src = SRC_PIXEL;
        end
    end

    // Underflow hold state: cleared on restart, else follows hold_d.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (start) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= hold_d;
        end
    end

    // Registered panel outputs with polarity applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_o <= 1'b0;
            vsync_o <= 1'b0;
            de_o    <= 1'b0;
            fs_o    <= 1'b0;
            uf_o    <= 1'b0;
            rgb_o   <= '0;
        end else begin
            hsync_o <= (run && zone.hs) ^ pol[0];
            vsync_o <= (run && zone.vs) ^ pol[1];
            de_o    <= (run && zone.disp) ^ pol[2];
            fs_o    <= fzero;
            uf_o    <= uf_o || starve;
            case (src)
                SRC_BORDER: rgb_o <= border;
                SRC_PIXEL:  rgb_o <= pix_data;
                SRC_UFLOW:  rgb_o <= uflow_color;
                default:    rgb_o <= '0;
            endcase
        end
    end

endmodule

// File: rtl/lcd_timing_gen.sv
// Panel timing generator top: connects counters, region decode and the
// output stage. Horizontal fields are packed as {end/period, start/width}
// in 2*HW-bit words. The underflow word carries the recovery enable in
// its top bit. The configuration must stay stable while running.
module lcd_timing_gen #(
    parameter int HW = 16,
    parameter int FW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [2*HW-1:0] cfg_hctl,
    input  logic [FW-1:0] cfg_frame_len,
    input  logic [FW-1:0] cfg_vs_len,
    input  logic [FW-1:0] cfg_skew,
    input  logic [2*HW-1:0] cfg_disp_h,
    input  logic [FW-1:0] cfg_disp_vs,
    input  logic [FW-1:0] cfg_disp_ve,
    input  logic          cfg_win_h_en,
    input  logic [2*HW-1:0] cfg_win_h,
    input  logic          cfg_win_v_en,
    input  logic [FW-1:0] cfg_win_vs,
    input  logic [FW-1:0] cfg_win_ve,
    input  logic [2:0]    cfg_pol,
    input  logic [CW-1:0] cfg_border,
    input  logic [CW:0]   cfg_uflow,
    input  logic          pix_valid,
    input  logic [CW-1:0] pix_data,
    output logic          pix_ready,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [CW-1:0] rgb,
    output logic          frame_start,
    output logic          underflow
);
    localparam int HLO = 0;
    localparam int HHI = HW;

    logic             run_q;
    logic [HW-1:0]    hcnt_q;
    logic [FW-1:0]    fcnt_q;
    logic             start_p;
    logic             fzero;
    lcdtg_pkg::zone_t zone;

    lcdtg_scan_ctr #(.HW(HW), .FW(FW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .line_len  (cfg_hctl[HHI +: HW]),
        .frame_len (cfg_frame_len),
        .run_q     (run_q),
        .hcnt_q    (hcnt_q),
        .fcnt_q    (fcnt_q),
        .start_o   (start_p),
        .fzero_o   (fzero)
    );

    lcdtg_window #(.HW(HW), .FW(FW)) u_win (
        .hcnt         (hcnt_q),
        .fcnt         (fcnt_q),
        .hs_len       (cfg_hctl[HLO +: HW]),
        .vs_len       (cfg_vs_len),
        .skew         (cfg_skew),
        .disp_h_start (cfg_disp_h[HLO +: HW]),
        .disp_h_end   (cfg_disp_h[HHI +: HW]),
        .disp_v_start (cfg_disp_vs),
        .disp_v_end   (cfg_disp_ve),
        .win_h_en     (cfg_win_h_en),
        .win_h_start  (cfg_win_h[HLO +: HW]),
        .win_h_end    (cfg_win_h[HHI +: HW]),
        .win_v_en     (cfg_win_v_en),
        .win_v_start  (cfg_win_vs),
        .win_v_end    (cfg_win_ve),
        .zone         (zone)
    );

    lcdtg_pixel_out #(.CW(CW)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run_q),
        .fzero       (fzero),
        .start       (start_p),
        .zone        (zone),
        .pol         (cfg_pol),
        .border      (cfg_border),
        .uflow_color (cfg_uflow[CW-1:0]),
        .recover     (cfg_uflow[CW]),
        .pix_valid   (pix_valid),
        .pix_data    (pix_data),
        .pix_ready   (pix_ready),
        .hsync_o     (hsync),
        .vsync_o     (vsync),
        .de_o        (de),
        .rgb_o       (rgb),
        .fs_o        (frame_start),
        .uf_o        (underflow)
    );

endmodule

// File: rtl/lcd_timing_gen_chk.sv
// Property checker for lcd_timing_gen, attached by bind below.
// Assumes the configuration is held stable while the generator runs.
module lcd_timing_gen_chk #(
    parameter int HW = 16,
    parameter int FW = 32,
    parameter int CW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_en,
    input logic [HW-1:0] line_len,
    input logic [FW-1:0] frame_len,
    input logic          run_q,
    input logic [HW-1:0] hcnt_q,
    input logic [FW-1:0] fcnt_q,
    input logic          pix_ready,
    input logic          frame_start,
    input logic          underflow,
    input logic [CW-1:0] rgb
);
    // R1: line position never reaches the line period
    a_r1_hcnt_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && line_len != '0) |-> (hcnt_q < line_len));

    // R2: frame index never reaches the frame length
    a_r2_fcnt_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && frame_len != '0) |-> (fcnt_q < frame_len));

    // R5: source is only read while running
    a_r5_ready_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> run_q);

    // R7: underflow flag is sticky
    a_r7_uf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R8: generator stops only after run_en was cleared
    a_r8_stop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> !$past(run_en));

    // R8: stopped generator drives a black pixel
    a_r8_idle_black: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> (rgb == '0));

    // R9: frame start lasts one cycle for frames longer than one pixel
    a_r9_fs_single: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && frame_len > 1) |=> !frame_start);

endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.HW(HW), .FW(FW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .line_len    (cfg_hctl[2*HW-1:HW]),
    .frame_len   (cfg_frame_len),
    .run_q       (run_q),
    .hcnt_q      (hcnt_q),
    .fcnt_q      (fcnt_q),
    .pix_ready   (pix_ready),
    .frame_start (frame_start),
    .underflow   (underflow),
    .rgb         (rgb)
);

// File: tb/lcd_timing_gen_test.sv
// Scoreboard bench: a driver task predicts every pixel of a run into a
// queue, a monitor pops and compares once frame_start is seen.
module lcd_timing_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 16;
    localparam int FW = 32;
    localparam int CW = 24;
    localparam int L   = 12;
    localparam int HSW = 2;
    localparam int HBP = 2;
    localparam int HFP = 2;
    localparam int VSL = 1;
    localparam int VBP = 1;
    localparam int VH  = 4;
    localparam int VFP = 1;
    localparam int F   = L * (VSL + VBP + VH + VFP);
    localparam int DHS = HSW + HBP;
    localparam int DHE = L - HFP - 1;
    localparam int WHS = 5;
    localparam int WHE = 7;
    localparam logic [CW-1:0] BORDER = 24'h00A0F0;
    localparam logic [CW-1:0] UCOLOR = 24'hF00F0F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic [2*HW-1:0] cfg_hctl = '0;
    logic [FW-1:0] cfg_frame_len = '0;
    logic [FW-1:0] cfg_vs_len = '0;
    logic [FW-1:0] cfg_skew = '0;
    logic [2*HW-1:0] cfg_disp_h = '0;
    logic [FW-1:0] cfg_disp_vs = '0;
    logic [FW-1:0] cfg_disp_ve = '0;
    logic cfg_win_h_en = 1'b0;
    logic [2*HW-1:0] cfg_win_h = '0;
    logic cfg_win_v_en = 1'b0;
    logic [FW-1:0] cfg_win_vs = '0;
    logic [FW-1:0] cfg_win_ve = '0;
    logic [2:0] cfg_pol = '0;
    logic [CW-1:0] cfg_border = '0;
    logic [CW:0] cfg_uflow = '0;
    logic pix_valid = 1'b1;
    logic [CW-1:0] pix_data = '0;
    logic pix_ready, hsync, vsync, de, frame_start, underflow;
    logic [CW-1:0] rgb;

    lcd_timing_gen #(.HW(HW), .FW(FW), .CW(CW)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic hs, vs, de, fs, uf;
        logic [CW-1:0] rgb;
        string tag;
        int px;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int n_vec = 0;
    int n_bad = 0;
    bit armed = 0;
    bit finished = 0;
    bit exp_uf = 0;

    // source model state
    int src_idx = 0;
    int src_slot = 0;
    bit src_take = 0;
    bit src_stv = 0;
    int src_stv_slot = 0;

    function automatic logic [CW-1:0] pat(int i);
        return CW'(32'h00112233 + i * 32'h00030507);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string msg);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    // Pixel source: advances on accepted pixels, starves one chosen request.
    always @(negedge clk) begin
        if (src_take) src_idx++;
        pix_data = pat(src_idx);
        if (pix_ready) begin
            pix_valid = !(src_stv && src_slot == src_stv_slot);
            src_slot++;
        end else begin
            pix_valid = 1'b1;
        end
        src_take = pix_ready && pix_valid;
    end

    // Monitor: arms on frame_start, compares one expected item per cycle.
    always @(negedge clk) begin
        if (!armed && frame_start === 1'b1 && q.size() > 0) armed = 1;
        if (armed) begin
            if (q.size() == 0) begin
                armed = 0;
            end else begin
                string t;
                e = q.pop_front();
                t = "";
                if (hsync !== e.hs)            t = "R1 R6 hsync";
                else if (vsync !== e.vs)       t = "R2 R6 vsync";
                else if (de !== e.de)          t = "R3 R6 de";
                else if (frame_start !== e.fs) t = "R9 frame_start";
                else if (underflow !== e.uf)   t = "R7 underflow";
                else if (rgb !== e.rgb)        t = e.tag;
                check(t == "", $sformatf("%s px %0d: got hs%b vs%b de%b fs%b uf%b rgb %h, expected hs%b vs%b de%b fs%b uf%b rgb %h",
                    t, e.px, hsync, vsync, de, frame_start, underflow, rgb,
                    e.hs, e.vs, e.de, e.fs, e.uf, e.rgb));
            end
        end
    end

    // Driver: configure, predict a whole run, start, stop, then check idle.
    task automatic run_case(input int nfr, input bit win, input logic [2:0] pol,
                            input int skew, input bit stv, input int stv_slot,
                            input bit rec);
        int dvs, dve, wvs, wve, idx, slot, lat;
        bit hold;
        dvs = (VSL + VBP) * L + skew;
        dve = F - VFP * L + skew - 1;
        wvs = dvs + L;
        wve = wvs + 2 * L - 1;
        @(negedge clk);
        cfg_hctl      = {HW'(L), HW'(HSW)};
        cfg_frame_len = FW'(F);
        cfg_vs_len    = FW'(VSL * L);
        cfg_skew      = FW'(skew);
        cfg_disp_h    = {HW'(DHE), HW'(DHS)};
        cfg_disp_vs   = FW'(dvs);
        cfg_disp_ve   = FW'(dve);
        cfg_win_h_en  = win;
        cfg_win_h     = {HW'(WHE), HW'(WHS)};
        cfg_win_v_en  = win;
        cfg_win_vs    = FW'(wvs);
        cfg_win_ve    = FW'(wve);
        cfg_pol       = pol;
        cfg_border    = BORDER;
        cfg_uflow     = {rec, UCOLOR};
        hold = 0; idx = 0; slot = 0;
        for (int fr = 0; fr < nfr; fr++) begin
            for (int p = 0; p < F; p++) begin
                exp_t it;
                int h;
                bit dsp, act;
                h = p % L;
                if (p == 0 && rec) hold = 0;
                dsp = (h >= DHS) && (h <= DHE) && (p >= dvs) && (p <= dve);
                act = dsp && (!win || ((h >= WHS) && (h <= WHE) && (p >= wvs) && (p <= wve)));
                if (!dsp) begin
                    it.rgb = '0; it.tag = "R5 blank";
                end else if (!act) begin
                    it.rgb = BORDER; it.tag = "R4 border";
                end else if (hold) begin
                    it.rgb = UCOLOR; it.tag = "R7 hold";
                end else if (stv && slot == stv_slot) begin
                    it.rgb = UCOLOR; it.tag = "R7 starve";
                    hold = 1; exp_uf = 1; slot++;
                end else begin
                    it.rgb = pat(idx); it.tag = "R5 data";
                    idx++; slot++;
                end
                it.hs = (h < HSW) ^ pol[0];
                it.vs = (p >= skew && p < skew + VSL * L) ^ pol[1];
                it.de = dsp ^ pol[2];
                it.fs = (p == 0);
                it.uf = exp_uf;
                it.px = fr * F + p;
                q.push_back(it);
            end
        end
        src_idx = 0; src_slot = 0; src_take = 0;
        src_stv = stv; src_stv_slot = stv_slot;
        run_en = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (frame_start !== 1'b1 && lat < 10);
        // R8: pixel 0 appears at the second edge after run_en rises
        check(lat == 2, $sformatf("R8 start latency got %0d expected 2", lat));
        repeat ((nfr - 1) * F + 3) @(negedge clk);
        run_en = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        // R8 R6: idle outputs after the frame finished
        check(hsync === pol[0] && vsync === pol[1] && de === pol[2] &&
              rgb === '0 && frame_start === 1'b0,
              $sformatf("R8 R6 idle got hs%b vs%b de%b rgb %h fs%b expected hs%b vs%b de%b rgb 0 fs0",
                        hsync, vsync, de, rgb, frame_start, pol[0], pol[1], pol[2]));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_uf = 0;
        @(negedge clk);
        // R8 R7: reset state
        check(hsync === 1'b0 && vsync === 1'b0 && de === 1'b0 && rgb === '0 &&
              frame_start === 1'b0 && underflow === 1'b0 && pix_ready === 1'b0,
              $sformatf("R8 R7 reset got hs%b vs%b de%b rgb %h fs%b uf%b rdy%b expected all 0",
                        hsync, vsync, de, rgb, frame_start, underflow, pix_ready));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired (R8) got running expected finished");
        finish_run();
    end

    initial begin
        do_reset();
        run_case(2, 0, 3'b000, 0, 0, 0, 0);   // R1 R2 R3 R5 R9 plain frames
        run_case(1, 1, 3'b101, 3, 0, 0, 0);   // R4 R6 window, polarity, skew
        run_case(2, 1, 3'b000, 0, 1, 4, 1);   // R7 starve with recovery
        do_reset();                           // R7 sticky cleared by reset
        run_case(2, 0, 3'b010, 0, 1, 7, 0);   // R7 starve without recovery
        run_case(1, 0, 3'b000, 5, 0, 0, 0);   // R7 restart clears hold
        finish_run();
    end

endmodule